// File: doc/BRIEF.md
# Banked ROM Address Decoder

This block sits between an 8-bit processor with a 16-bit address space and a set of nine 32K x 8 ROM devices. The top quarter of memory, C000-FFFF, always shows the system ROM. The quarter below it, 8000-BFFF, is a 16K window. It shows one of seventeen 16K banks, so 272K of ROM can be reached in total. The processor picks the bank by writing a byte to a selection register in the I/O page. The block also decodes that I/O page into three strobes. One is for the interface controller, one is for a switch data buffer and one is for the bank-selection register itself.

The selection byte has three fields. Bits 3..1 name one of eight paired-bank devices. Bit 0 picks the half of that device, so the even bank is the lower half and the odd bank is the upper half. Bit 4 is an escape bit. When it is set, the window shows bank 16, which is the lower half of the device that holds the system ROM in its upper half. For banks 0-15, the byte value equals the bank number. Bank 16 is written as 0x10. Bits 7..5 have no effect.

All chip enables are active high and combinational from the address and the stored byte. Every pin is a plain control or status signal. No pin carries a data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `banked_rom_decoder`

## Requirements
- R1: For any address C000-FFFF, `sys_rom_ce` is 1, `bank_rom_ce` is all zero and `rom_addr[14]` is 1, whatever byte is stored.
- R2: On a rising clock edge where `cpu_wr`, `cpu_phase` and `banksel_en` are all high, the register stores `cpu_data`. The new selection applies from the next cycle, and each later write replaces it.
- R3: With bit 4 of the stored byte low, an address in 8000-BFFF raises only `bank_rom_ce[n]`, where n is the value of bits 3..1. `sys_rom_ce` stays 0.
- R4: With bit 4 high, an address in 8000-BFFF raises `sys_rom_ce` with `rom_addr[14]` = 0, and `bank_rom_ce` is all zero.
- R5: `rom_addr[13:0]` always equals `cpu_addr[13:0]`. In 8000-BFFF with bit 4 low, `rom_addr[14]` equals bit 0 of the stored byte (0 = even bank, 1 = odd bank).
- R6: For addresses 0000-7FFF, every ROM enable is 0 and `rom_addr[14]` is 0.
- R7: The I/O strobes fire only while `cpu_phase` is 1 and `cpu_addr[15:11]` = 01111. Bits 10..9 then select the strobe: 00 gives `ioc_en`, 10 gives `switch_en`, 11 gives `banksel_en` and 01 gives none. At most one strobe is high at a time.
- R8: `diag_led` is the one-hot decode of bits 3..1 when bit 4 is low and is all zero when bit 4 is high. It does not depend on the address.
- R9: Reset (`rst_n` low) clears the register to 0x00, which selects bank 0.
- R10: The register does not change on a read of 7E00, on a write there with `cpu_phase` low, or on a write to any other address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_addr | input | 16 | Processor address |
| cpu_data | input | 8 | Processor write data |
| cpu_wr | input | 1 | Write strobe (1 = write) |
| cpu_phase | input | 1 | Clock-phase qualifier for I/O strobes |
| sys_rom_ce | output | 1 | Enable for the system/bank-16 device |
| bank_rom_ce | output | 8 | Enables for the eight paired-bank devices |
| rom_addr | output | 15 | Device address; bit 14 picks the half |
| ioc_en | output | 1 | Interface controller page strobe (7800) |
| switch_en | output | 1 | Switch data buffer strobe (7C00) |
| banksel_en | output | 1 | Bank-selection register strobe (7E00) |
| diag_led | output | 8 | Decoded device select for indicators |

## Verification
The bench builds the block with its defaults: 16 address bits, 8 data bits and a 3-bit device field. With these values, all seventeen banks can be selected by writing byte values 0-16, and the window is checked at both of its edges for each one. The same defaults place the I/O page at 7800-7FFF. That makes every two-bit slot code reachable, including the unused one, and it lets the ignored-write cases be tried at addresses next to the register.

// File: rtl/banked_rom_pkg.sv
`timescale 1ns/1ps
package banked_rom_pkg;
  // Slot code taken from address bits 10..9 inside the I/O page
  typedef enum logic [1:0] {
    SLOT_CTRL    = 2'b00,
    SLOT_SPARE   = 2'b01,
    SLOT_SWITCH  = 2'b10,
    SLOT_BANKSEL = 2'b11
  } io_slot_e;

  // Quarter of the address space from the top two address bits
  typedef enum logic [1:0] {
    WIN_LOW_A  = 2'b00,
    WIN_LOW_B  = 2'b01,
    WIN_BANKED = 2'b10,
    WIN_SYSTEM = 2'b11
  } win_e;
endpackage

// File: rtl/brd_io_decode.sv
`timescale 1ns/1ps
module brd_io_decode
  import banked_rom_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int PAGE_TAG = 'h0F,
  localparam int HI_W    = ADDR_W - 9,
  localparam int PAGE_W  = ADDR_W - 11
) (
  input  logic [HI_W-1:0] addr_hi,   // cpu address bits ADDR_W-1..9
  input  logic            phase,
  output logic            ctrl_en,
  output logic            switch_en,
  output logic            banksel_en
);
  logic     in_page;
  io_slot_e slot;

  assign in_page = (addr_hi[HI_W-1:2] == PAGE_W'(PAGE_TAG));
  assign slot    = io_slot_e'(addr_hi[1:0]);

  always_comb begin
    ctrl_en    = 1'b0;
    switch_en  = 1'b0;
    banksel_en = 1'b0;
    if (in_page && phase) begin
      case (slot)
        SLOT_CTRL:    ctrl_en    = 1'b1;
        SLOT_SWITCH:  switch_en  = 1'b1;
        SLOT_BANKSEL: banksel_en = 1'b1;
        default:      ;
      endcase
    end
  end
endmodule

// File: rtl/brd_bank_reg.sv
`timescale 1ns/1ps
module brd_bank_reg #(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [REG_W-1:0] din,
  output logic [REG_W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= din;
  end
endmodule

// File: rtl/brd_rom_select.sv
`timescale 1ns/1ps
module brd_rom_select
  import banked_rom_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int SEL_W    = 3,
  localparam int NUM_DEV = 1 << SEL_W,
  localparam int REG_W   = SEL_W + 2,
  localparam int ESC_BIT = SEL_W + 1,
  localparam int DEV_AW  = ADDR_W - 1
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic [REG_W-1:0]   bank,
  output logic               sys_ce,
  output logic [NUM_DEV-1:0] dev_ce,
  output logic [DEV_AW-1:0]  dev_addr,
  output logic [NUM_DEV-1:0] diag
);
  win_e             win;
  logic             escape;
  logic             half;
  logic [SEL_W-1:0] sel;
  logic             top_bit;

  assign win    = win_e'(addr[ADDR_W-1 -: 2]);
  assign escape = bank[ESC_BIT];
  assign sel    = bank[SEL_W:1];
  assign half   = bank[0];

  // One-hot device decode from the stored selection only
  for (genvar g = 0; g < NUM_DEV; g++) begin : g_dev
    assign diag[g] = !escape && (sel == SEL_W'(g));
  end

  always_comb begin
    sys_ce  = 1'b0;
    dev_ce  = '0;
    top_bit = 1'b0;
    case (win)
      WIN_SYSTEM: begin
        sys_ce  = 1'b1;
        top_bit = 1'b1;
      end
      WIN_BANKED: begin
        if (escape) begin
          sys_ce  = 1'b1;
          top_bit = 1'b0;
        end else begin
          dev_ce  = diag;
          top_bit = half;
        end
      end
      default: ;
    endcase
  end

  assign dev_addr = {top_bit, addr[ADDR_W-3:0]};
endmodule

// File: rtl/banked_rom_decoder.sv
`timescale 1ns/1ps
module banked_rom_decoder #(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int SEL_W    = 3,
  parameter int PAGE_TAG = 'h0F,
  localparam int NUM_DEV = 1 << SEL_W,
  localparam int REG_W   = SEL_W + 2,
  localparam int DEV_AW  = ADDR_W - 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  cpu_addr,
  input  logic [DATA_W-1:0]  cpu_data,
  input  logic               cpu_wr,
  input  logic               cpu_phase,
  output logic               sys_rom_ce,
  output logic [NUM_DEV-1:0] bank_rom_ce,
  output logic [DEV_AW-1:0]  rom_addr,
  output logic               ioc_en,
  output logic               switch_en,
  output logic               banksel_en,
  output logic [NUM_DEV-1:0] diag_led
);
  logic [REG_W-1:0] bank_q;
  logic             bank_load;
  logic             unused_bits;

  assign unused_bits = ^{cpu_data[DATA_W-1:REG_W], cpu_addr[8:0]};

  brd_io_decode #(.ADDR_W(ADDR_W), .PAGE_TAG(PAGE_TAG)) u_io (
    .addr_hi    (cpu_addr[ADDR_W-1:9]),
    .phase      (cpu_phase),
    .ctrl_en    (ioc_en),
    .switch_en  (switch_en),
    .banksel_en (banksel_en)
  );

  assign bank_load = banksel_en && cpu_wr;

  brd_bank_reg #(.REG_W(REG_W)) u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (bank_load),
    .din   (cpu_data[REG_W-1:0]),
    .q     (bank_q)
  );

  brd_rom_select #(.ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_sel (
    .addr     (cpu_addr),
    .bank     (bank_q),
    .sys_ce   (sys_rom_ce),
    .dev_ce   (bank_rom_ce),
    .dev_addr (rom_addr),
    .diag     (diag_led)
  );
endmodule

// File: rtl/banked_rom_decoder_chk.sv
`timescale 1ns/1ps
module banked_rom_decoder_chk #(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int SEL_W    = 3,
  localparam int NUM_DEV = 1 << SEL_W,
  localparam int DEV_AW  = ADDR_W - 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic [ADDR_W-1:0]  cpu_addr,
  input logic [DATA_W-1:0]  cpu_data,
  input logic               cpu_wr,
  input logic               cpu_phase,
  input logic               sys_rom_ce,
  input logic [NUM_DEV-1:0] bank_rom_ce,
  input logic [DEV_AW-1:0]  rom_addr,
  input logic               ioc_en,
  input logic               switch_en,
  input logic               banksel_en,
  input logic [NUM_DEV-1:0] diag_led
);
  a_r1_system_window: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[ADDR_W-1 -: 2] == 2'b11) |-> (sys_rom_ce && bank_rom_ce == '0 && rom_addr[DEV_AW-1]));

  a_r2_load_select: assert property (@(posedge clk) disable iff (!rst_n)
    (banksel_en && cpu_wr && !cpu_data[SEL_W+1]) |=>
      (diag_led == (NUM_DEV'(1) << $past(cpu_data[SEL_W:1]))));

  a_r3_single_device: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_rom_ce) && !(sys_rom_ce && bank_rom_ce != '0));

  a_r4_escape_low_half: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[ADDR_W-1 -: 2] == 2'b10 && sys_rom_ce) |-> !rom_addr[DEV_AW-1]);

  a_r5_low_bits_pass: assert property (@(posedge clk) disable iff (!rst_n)
    rom_addr[ADDR_W-3:0] == cpu_addr[ADDR_W-3:0]);

  a_r6_outside_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_addr[ADDR_W-1] |-> (!sys_rom_ce && bank_rom_ce == '0));

  a_r7_strobe_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ioc_en, switch_en, banksel_en}));

  a_r7_phase_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_phase |-> !(ioc_en || switch_en || banksel_en));

  a_r8_diag_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(diag_led));

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(banksel_en && cpu_wr) |=> $stable(diag_led));
endmodule

bind banked_rom_decoder banked_rom_decoder_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEL_W(SEL_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
  .cpu_wr(cpu_wr), .cpu_phase(cpu_phase), .sys_rom_ce(sys_rom_ce),
  .bank_rom_ce(bank_rom_ce), .rom_addr(rom_addr), .ioc_en(ioc_en),
  .switch_en(switch_en), .banksel_en(banksel_en), .diag_led(diag_led)
);

// File: tb/banked_rom_decoder_bench.sv
`timescale 1ns/1ps
module banked_rom_decoder_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_data = '0;
  logic        cpu_wr = 1'b0;
  logic        cpu_phase = 1'b0;
  logic        sys_rom_ce;
  logic [7:0]  bank_rom_ce;
  logic [14:0] rom_addr;
  logic        ioc_en, switch_en, banksel_en;
  logic [7:0]  diag_led;

  int checks = 0;
  int errors = 0;
  int ref_bank = 0;   // model of the stored selection byte
  bit done = 0;

  always #2.5 clk = ~clk;

  banked_rom_decoder u_banked_rom_decoder (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
    .cpu_wr(cpu_wr), .cpu_phase(cpu_phase), .sys_rom_ce(sys_rom_ce),
    .bank_rom_ce(bank_rom_ce), .rom_addr(rom_addr), .ioc_en(ioc_en),
    .switch_en(switch_en), .banksel_en(banksel_en), .diag_led(diag_led)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h (addr=%h bank=%0h)", tag, act, exp, cpu_addr, ref_bank);
    end
  endtask

  // Expected device diag pattern from the model byte
  function automatic int exp_diag();
    if ((ref_bank & 'h10) != 0) return 0;
    return 1 << ((ref_bank >> 1) & 7);
  endfunction

  task automatic compare();
    int a = int'(cpu_addr);
    int bank_no = ((ref_bank & 'h10) != 0) ? 16 : (ref_bank & 'hF);
    int e_sys = 0, e_ce = 0, e_hi = 0;
    int io_slot = (a >> 9) & 3;
    bit in_page = (((a >> 11) & 'h1F) == 'h0F) && cpu_phase;
    string t;
    if (a >= 'hC000) begin e_sys = 1; e_hi = 1; t = "R1"; end
    else if (a >= 'h8000) begin
      if (bank_no == 16) begin e_sys = 1; e_hi = 0; t = "R4"; end
      else begin e_ce = 1 << (bank_no / 2); e_hi = bank_no % 2; t = "R3"; end
    end else t = "R6";
    chk(sys_rom_ce == e_sys[0], t, sys_rom_ce, e_sys);
    chk(int'(bank_rom_ce) == e_ce, t, bank_rom_ce, e_ce);
    chk(rom_addr[14] == e_hi[0], (a >= 'h8000) ? "R5" : "R6", rom_addr[14], e_hi);
    chk(rom_addr[13:0] == cpu_addr[13:0], "R5", rom_addr[13:0], cpu_addr[13:0]);
    chk(int'(diag_led) == exp_diag(), "R8", diag_led, exp_diag());
    chk({ioc_en, switch_en, banksel_en} ==
        {in_page && io_slot == 0, in_page && io_slot == 2, in_page && io_slot == 3},
        "R7", {ioc_en, switch_en, banksel_en},
        {in_page && io_slot == 0, in_page && io_slot == 2, in_page && io_slot == 3});
  endtask

  task automatic step(input logic [15:0] a, input logic [7:0] d, input logic w, input logic p);
    @(negedge clk);
    cpu_addr = a; cpu_data = d; cpu_wr = w; cpu_phase = p;
    #1;
    compare();
    @(posedge clk);
    if (w && p && a[15:9] == 7'b0111111) ref_bank = int'(d);
  endtask

  task automatic check_diag(input string tag, input int exp);
    @(negedge clk);
    cpu_wr = 1'b0; cpu_phase = 1'b0; cpu_addr = 16'h0000;
    #1;
    chk(int'(diag_led) == exp, tag, diag_led, exp);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R9: bank 0 after reset
    check_diag("R9", 1);
    step(16'h8000, 8'h00, 1'b0, 1'b1);
    step(16'hC123, 8'h00, 1'b0, 1'b1);
    // R2 / R3 / R4 / R5: sweep all seventeen banks
    for (int b = 0; b <= 16; b++) begin
      step(16'h7E00, 8'(b), 1'b1, 1'b1);
      check_diag("R2", exp_diag());
      step(16'h8000, 8'h00, 1'b0, 1'b1);
      step(16'hBFFF, 8'h00, 1'b0, 1'b0);
      step(16'hA5A5, 8'h00, 1'b0, 1'b1);
      step(16'hC000, 8'h00, 1'b0, 1'b1);
      step(16'hFFFF, 8'h00, 1'b0, 1'b0);
      step(16'h7FFF, 8'h00, 1'b0, 1'b0);
      step(16'h1234, 8'h00, 1'b0, 1'b1);
    end
    // Upper bits ignored: 0xE7 selects bank 7
    step(16'h7E00, 8'hE7, 1'b1, 1'b1);
    check_diag("R2", 'h08);
    step(16'h9000, 8'h00, 1'b0, 1'b1);
    // R10: reads, unqualified writes and writes elsewhere leave it alone
    step(16'h7E00, 8'h02, 1'b0, 1'b1);
    check_diag("R10", 'h08);
    step(16'h7E00, 8'h02, 1'b1, 1'b0);
    check_diag("R10", 'h08);
    step(16'h7C00, 8'h02, 1'b1, 1'b1);
    step(16'h7800, 8'h02, 1'b1, 1'b1);
    step(16'h7A00, 8'h02, 1'b1, 1'b1);
    step(16'h3E00, 8'h02, 1'b1, 1'b1);
    step(16'hFE00, 8'h02, 1'b1, 1'b1);
    check_diag("R10", 'h08);
    step(16'hA000, 8'h00, 1'b0, 1'b1);
    // R7: all slots with and without the phase qualifier
    for (int s = 0; s < 4; s++) begin
      step(16'h7800 | 16'(s << 9), 8'h00, 1'b0, 1'b1);
      step(16'h7800 | 16'(s << 9) | 16'h01FF, 8'h00, 1'b0, 1'b0);
      step(16'h7000 | 16'(s << 9), 8'h00, 1'b0, 1'b1);
    end
    // R2: back-to-back writes, last one wins
    step(16'h7E00, 8'h03, 1'b1, 1'b1);
    step(16'h7FFF, 8'h0C, 1'b1, 1'b1);
    check_diag("R2", 'h40);
    step(16'h8001, 8'h00, 1'b0, 1'b1);
    // R9: reset again clears a nonzero selection
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1; ref_bank = 0;
    check_diag("R9", 1);
    step(16'hB000, 8'h00, 1'b0, 1'b1);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule